// File: doc/BRIEF.md
# Two-Phase Peripheral Bus Master

This block sits between a simple command port and a low-power peripheral bus. A client raises a request together with a 32-bit address, a write flag and write data. The block latches the command and runs a fixed two-cycle bus transfer. The first cycle raises the target slave's select line. The second cycle adds the enable strobe. There are no wait states and no slave response, so every transfer finishes on the edge that closes its enable cycle.

Four slaves each own a 4 KB window. The target is chosen by address bits [13:12]; the higher address bits are passed to the bus but take no part in slave selection. Read data is sampled at the end of the enable cycle and returned with a one-cycle done pulse. A command that is waiting while an enable cycle is in progress is taken on the edge that closes that cycle. Its setup cycle then follows at once, with no idle cycle between the two transfers.

Top module: `pbus_master`

## Requirements
- R1: Each accepted command produces exactly one setup cycle (select high, enable low) followed by exactly one enable cycle (select and enable high).
- R2: `bus_en` is high only in the second cycle of a transfer and is never high in two consecutive cycles unless a setup cycle lies between them.
- R3: `bus_sel` is one-hot during a transfer, with bit k set when latched address bits [13:12] equal k, so slave k owns bytes k*4096 to k*4096+4095 modulo 16 KB. Address bits above bit 13 do not affect selection. `bus_sel` is all zero when no transfer runs.
- R4: `bus_write` is 1 for a write command and 0 for a read command.
- R5: `bus_addr`, `bus_write`, `bus_wdata` and `bus_sel` hold the same values through both cycles of a transfer.
- R6: For a read, `bus_rdata` is captured on the rising edge that ends the enable cycle. It appears on `rsp_rdata` from the next cycle and is held until the next read completes. A write leaves `rsp_rdata` unchanged.
- R7: `rsp_done` is high for exactly one cycle, the cycle after each enable cycle, for reads and writes alike.
- R8: `cmd_ready` is low during setup cycles and high while idle and during enable cycles. A command is accepted on a rising edge where `cmd_req` and `cmd_ready` are both high.
- R9: A command accepted at the end of an enable cycle starts its setup cycle immediately, with no idle cycle in between.
- R10: While `rst_n` is low, the block is idle with `bus_sel`=0, `bus_en`=0, `rsp_done`=0, `cmd_ready`=1, and `rsp_rdata`, `bus_addr`, `bus_wdata` and `bus_write` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req | input | 1 | Command request |
| cmd_addr | input | 32 | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 32 | Command write data |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_req` |
| rsp_rdata | output | 32 | Last captured read data |
| rsp_done | output | 1 | One-cycle transfer completion pulse |
| bus_addr | output | 32 | Latched bus address |
| bus_sel | output | 4 | One select line per slave |
| bus_en | output | 1 | Enable strobe, second transfer cycle |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | 32 | Latched write data |
| bus_rdata | input | 32 | Read data from the selected slave |

## Verification
On every cycle the assertions check the shape of each transfer. Enable must follow a setup cycle, and the selects must stay one-hot and be present under enable. Address, direction, data and select must hold steady through the enable cycle, `rsp_done` must follow an enable cycle, and ready must be low in setup. Only the bench scenarios can show that the right slave is decoded for each window, including aliased high addresses. The same holds for checking that captured read data equals what the addressed slave returned, that writes leave the read result alone, and that back-to-back commands run without a gap.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;
endpackage

// File: rtl/pbus_fsm.sv
module pbus_fsm
  import pbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_req,
  output phase_t phase,
  output logic   take_cmd
);
  phase_t phase_nxt;

  assign take_cmd = cmd_req && (phase == PH_IDLE || phase == PH_ACCESS);

  always_comb begin
    phase_nxt = phase;
    case (phase)
      PH_IDLE:   if (cmd_req) phase_nxt = PH_SETUP;
      PH_SETUP:  phase_nxt = PH_ACCESS;
      PH_ACCESS: phase_nxt = cmd_req ? PH_SETUP : PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  // R1: a setup cycle is always followed by an access cycle
  assert_setup_then_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SETUP |=> phase == PH_ACCESS);
  // R9: a request during access leads straight to setup
  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACCESS && cmd_req) |=> phase == PH_SETUP);
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode #(
  parameter int NUM_SLV = 4,
  localparam int SEL_W = $clog2(NUM_SLV)
) (
  input  logic [SEL_W-1:0]   slot,
  input  logic               active,
  output logic [NUM_SLV-1:0] sel
);
  for (genvar k = 0; k < NUM_SLV; k++) begin : g_sel
    assign sel[k] = active && (slot == SEL_W'(k));
  end

  // R3: never more than one slave selected
  always_comb assert_sel_onehot_R3: assert (!$isunknown(sel) -> $onehot0(sel));
endmodule

// File: rtl/pbus_capture.sv
module pbus_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_access,
  input  logic              is_read,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);
  logic cap_en;
  assign cap_en = in_access && is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= in_access;
      if (cap_en) rsp_rdata <= bus_rdata;
    end
  end

  // R7: done follows an access cycle and lasts one cycle
  assert_done_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(in_access));
  // R6: read result only moves after a read access
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_en) |-> $stable(rsp_rdata));
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 4,
  parameter int SEL_LSB = 12,
  localparam int SEL_W = $clog2(NUM_SLV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_req,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               cmd_write,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               cmd_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_done,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [NUM_SLV-1:0] bus_sel,
  output logic               bus_en,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_write,
  output logic [DATA_W-1:0]  bus_wdata
);
  phase_t phase;
  logic   take_cmd;

  pbus_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_req  (cmd_req),
    .phase    (phase),
    .take_cmd (take_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
    end else if (take_cmd) begin
      bus_addr  <= cmd_addr;
      bus_write <= cmd_write;
      bus_wdata <= cmd_wdata;
    end
  end

  assign cmd_ready = (phase != PH_SETUP);
  assign bus_en    = (phase == PH_ACCESS);

  pbus_decode #(.NUM_SLV(NUM_SLV)) u_dec (
    .slot   (bus_addr[SEL_LSB +: SEL_W]),
    .active (phase != PH_IDLE),
    .sel    (bus_sel)
  );

  pbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_access (phase == PH_ACCESS),
    .is_read   (!bus_write),
    .bus_rdata (bus_rdata),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done)
  );

  // R2: enable only after a setup cycle
  assert_en_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> $past(bus_sel != '0 && !bus_en));
  // R3: a slave is selected whenever enable is high
  assert_sel_with_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> bus_sel != '0);
  // R5: transfer fields steady into the enable cycle
  assert_fields_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata) && $stable(bus_sel)));
  // R8: no command taken during setup
  assert_ready_low_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel != '0 && !bus_en) |-> !cmd_ready);
endmodule

// File: tb/pbus_master_test.sv
module pbus_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_req = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready;
  logic [31:0] rsp_rdata;
  logic        rsp_done;
  logic [31:0] bus_addr;
  logic [3:0]  bus_sel;
  logic        bus_en;
  logic [31:0] bus_rdata = '0;
  logic        bus_write;
  logic [31:0] bus_wdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pbus_master uut (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .bus_addr(bus_addr),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_rdata(bus_rdata),
    .bus_write(bus_write), .bus_wdata(bus_wdata)
  );

  function automatic logic [31:0] slave_val(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_0F96;
  endfunction

  // slave: returns a known value under enable, garbage otherwise
  always @(negedge clk) bus_rdata <= bus_en ? slave_val(bus_addr) : 32'hDEAD_BEEF;

  // reference model
  int          m_ph = 0;
  logic [31:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
  logic        m_wr = 1'b0, m_done = 1'b0, m_acc = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
      m_wr = 1'b0; m_done = 1'b0; m_acc = 1'b0;
    end else begin
      m_done = (m_ph == 2);
      m_acc = 1'b0;
      if (m_ph == 2 && !m_wr) m_rdata = slave_val(m_addr);
      if ((m_ph == 0 || m_ph == 2) && cmd_req) begin
        m_acc = 1'b1; m_addr = cmd_addr; m_wr = cmd_write; m_wdata = cmd_wdata; m_ph = 1;
      end else if (m_ph == 1) m_ph = 2;
      else m_ph = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] esel;
    esel = (m_ph != 0) ? (4'b1 << m_addr[13:12]) : 4'b0;
    chk("R3 select", {28'b0, bus_sel}, {28'b0, esel});
    chk("R1 R2 enable", {31'b0, bus_en}, {31'b0, m_ph == 2});
    chk("R8 ready", {31'b0, cmd_ready}, {31'b0, m_ph != 1});
    chk("R5 address", bus_addr, m_addr);
    chk("R4 direction", {31'b0, bus_write}, {31'b0, m_wr});
    chk("R5 wdata", bus_wdata, m_wdata);
    chk("R7 done", {31'b0, rsp_done}, {31'b0, m_done});
    chk("R6 rdata", rsp_rdata, m_rdata);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d);
    cmd_req = 1'b1; cmd_addr = a; cmd_write = w; cmd_wdata = d;
    do @(negedge clk); while (!m_acc);
  endtask

  task automatic quiet(input int n);
    cmd_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 ready", {31'b0, cmd_ready}, 32'd1);
    chk("R10 select", {28'b0, bus_sel}, 32'd0);
    chk("R10 rdata", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    quiet(2);
    // R3 R4: single writes into each window
    for (int k = 0; k < 4; k++) begin
      issue(32'h0000_0000 + k * 32'h1000 + 32'h0040, 1'b1, 32'hC0DE_0000 + k);
      quiet(3);
    end
    // R6: single reads, each window
    for (int k = 0; k < 4; k++) begin
      issue(32'h0000_0FFC + k * 32'h1000, 1'b0, 32'h0);
      quiet(2);
    end
    // R3: high address bits alias onto the four windows
    issue(32'hFFFF_3ABC, 1'b0, 32'h0); quiet(2);
    issue(32'h8000_0004, 1'b1, 32'h1234_5678); quiet(2);
    // R9: back-to-back mixed stream, R6 write leaves rdata alone
    for (int k = 0; k < 10; k++)
      issue(32'h1357_0000 + k * 32'h0000_1404, k[0], 32'hA000_0000 + k);
    quiet(4);
    // R9: long read burst with a held request
    for (int k = 0; k < 8; k++)
      issue(32'h0002_2000 + k * 32'h0000_3000, 1'b0, 32'h0);
    quiet(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule